// File: doc/BRIEF.md
# Chained Nonce Range Partitioner

This block gives one hashing chip in a serial chain its own share of the nonce space and then steps a counter through that share. It takes the chain length and the chip's position and turns them into an 8-bit range prefix. It then presents a four-byte range-setting command for that chip, one byte per handshake. On a work-start pulse it loads the start of the share into a nonce counter. The counter then advances by one on each enabled cycle.

The counter does not wrap. When it passes the last nonce of its share, it stops, drops the valid flag and raises an exhausted flag. It stays there until new work arrives. The exhausted flag lets the surrounding logic see that the chip has gone quiet, because power draw falls at that moment. Hashing, serial transmission and timer-driven rescheduling stay outside the block.

The nonce width is the parameter `NONCE_W` (default 32). The top 8 bits of the nonce are the prefix and the remaining `NONCE_W-8` bits are the low part.

Top module: `nonce_slice_walker`

## Requirements
- R1: The prefix is the truncated quotient 256 / count, multiplied by the index, keeping the low 8 bits. A count of 0 is treated as 1.
- R2: A `cfg_load` captures count and index. On the next cycle `cmd_valid` rises. The bytes 0x41, 0x05, prefix and 0x00 then follow in that order, one per cycle in which `cmd_valid` and `cmd_ready` are both high. After the fourth byte, `cmd_valid` falls.
- R3: While `cmd_valid` is high and `cmd_ready` is low, `cmd_byte` and `cmd_valid` stay unchanged.
- R4: One cycle after a `work_start` pulse, `nonce` equals the slice start {prefix, all zeros in the low part}, `nonce_valid` is 1 and `exhausted` is 0. This also holds when the pulse comes in the middle of a slice or after exhaustion.
- R5: While the walk is running, each cycle with `step_en` high presents the previous nonce plus one with `nonce_valid` high. A cycle with `step_en` low presents no new value, so `nonce_valid` is 0 on the next cycle.
- R6: The slice end is all ones for the last chip (index = count-1). For any other chip, it is one below the next chip's start, {prefix + 256/count, zeros} - 1.
- R7: A step taken while the nonce equals the slice end raises `exhausted`, clears `nonce_valid` and holds `nonce`. Further steps change nothing until the next `work_start`.
- R8: After reset, `cmd_valid`, `nonce_valid` and `exhausted` are 0. The captured slice is that of chip 0 of a one-chip chain.
- R9: With `CLAMP_INDEX`=1 (the default), an index at or above the count is treated as count-1.
- R10: With a count of 2, chip 0 starts at nonce 0 and chip 1 starts at the nonce whose top bit alone is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_count | input | CNT_W | Number of chips in the chain |
| chip_index | input | CNT_W | Position of this chip in the chain |
| cfg_load | input | 1 | Capture count and index, then start the command |
| cmd_ready | input | 1 | Downstream accepts the current command byte |
| cmd_valid | output | 1 | A command byte is presented |
| cmd_byte | output | 8 | Current command byte |
| work_start | input | 1 | Reload the counter at the slice start |
| step_en | input | 1 | Advance the counter this cycle |
| nonce | output | NONCE_W | Current nonce |
| nonce_valid | output | 1 | A new nonce is presented this cycle |
| exhausted | output | 1 | The slice is finished and the counter is idle |

## Verification
The partition is tried with two chips on each index and with the full 256-chip chain on its last index. It is also tried with three chips, where the truncated division leaves a slice wider than the others, with a count of zero, and with an out-of-range index. Between them these cases separate the truncation rule, the last-chip end rule and the clamp. Random counts, indices, ready stalls and step bursts check the prefix and the command byte order, and show that a stalled handshake holds its byte. Walks run to and past the slice end and show that the counter idles rather than wrapping. A restart in the middle of a slice and a restart after exhaustion show that a reload always wins.

// File: rtl/nsw_pkg.sv
package nsw_pkg;
   localparam logic [7:0] CMD_OP0  = 8'h41;
   localparam logic [7:0] CMD_OP1  = 8'h05;
   localparam logic [7:0] CMD_TAIL = 8'h00;
   localparam int unsigned PFX_W   = 8;

   typedef enum logic [2:0] {C_IDLE, C_B0, C_B1, C_B2, C_B3} cmd_st_t;
   typedef enum logic [1:0] {W_IDLE, W_RUN, W_DONE} walk_st_t;
endpackage

// File: rtl/nsw_slice_calc.sv
module nsw_slice_calc #(
   parameter int unsigned NONCE_W     = 32,
   parameter int unsigned CNT_W       = 9,
   parameter bit          CLAMP_INDEX = 1'b1
) (
   input  logic [CNT_W-1:0]   count,
   input  logic [CNT_W-1:0]   index,
   output logic [7:0]         prefix,
   output logic [NONCE_W-1:0] first,
   output logic [NONCE_W-1:0] last
);
   import nsw_pkg::*;
   localparam int unsigned LOW_W  = NONCE_W - PFX_W;
   localparam int unsigned SPAN_W = CNT_W + 9;

   if (NONCE_W <= PFX_W) begin : g_bad_width
      $error("NONCE_W must exceed the prefix width");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W too small");
   end

   logic [SPAN_W-1:0] cnt_x, idx_raw, idx_x, stride_x, lo_x, hi_x;
   logic              is_last;

   // R1: zero count behaves as a single chip
   assign cnt_x   = (count == '0) ? SPAN_W'(1) : SPAN_W'(count);
   assign idx_raw = SPAN_W'(index);

   if (CLAMP_INDEX) begin : g_clamp
      // R9: out-of-range index folds onto the last chip
      assign idx_x = (idx_raw >= cnt_x) ? cnt_x - SPAN_W'(1) : idx_raw;
   end else begin : g_raw
      assign idx_x = idx_raw;
   end

   assign stride_x = SPAN_W'(256) / cnt_x;
   assign lo_x     = stride_x * idx_x;
   assign hi_x     = lo_x + stride_x;
   assign is_last  = (idx_x + SPAN_W'(1)) >= cnt_x;

   assign prefix = lo_x[7:0];
   assign first  = {lo_x[7:0], {LOW_W{1'b0}}};
   assign last   = is_last ? {NONCE_W{1'b1}}
                           : ({hi_x[7:0], {LOW_W{1'b0}}} - NONCE_W'(1));
endmodule

// File: rtl/nsw_cmd_seq.sv
module nsw_cmd_seq (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [7:0] prefix,
   input  logic       ready,
   output logic       valid,
   output logic [7:0] data
);
   import nsw_pkg::*;
   cmd_st_t st;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= C_IDLE;
      end else if (load) begin
         st <= C_B0;
      end else if (valid && ready) begin
         unique case (st)
            C_B0:    st <= C_B1;
            C_B1:    st <= C_B2;
            C_B2:    st <= C_B3;
            default: st <= C_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (st)
         C_B0:    data = CMD_OP0;
         C_B1:    data = CMD_OP1;
         C_B2:    data = prefix;
         C_B3:    data = CMD_TAIL;
         default: data = 8'h00;
      endcase
   end
   assign valid = (st != C_IDLE);

   // R3: a stalled byte is held
   a_r3_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready && !load) |=> (valid && $stable(data)));
endmodule

// File: rtl/nsw_walker.sv
module nsw_walker #(
   parameter int unsigned NONCE_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               step,
   input  logic [NONCE_W-1:0] first,
   input  logic [NONCE_W-1:0] last,
   output logic [NONCE_W-1:0] nonce,
   output logic               nonce_valid,
   output logic               exhausted
);
   import nsw_pkg::*;
   walk_st_t st;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st          <= W_IDLE;
         nonce       <= '0;
         nonce_valid <= 1'b0;
      end else if (start) begin
         st          <= W_RUN;
         nonce       <= first;
         nonce_valid <= 1'b1;
      end else if (st == W_RUN && step) begin
         if (nonce == last) begin
            st          <= W_DONE;
            nonce_valid <= 1'b0;
         end else begin
            nonce       <= nonce + NONCE_W'(1);
            nonce_valid <= 1'b1;
         end
      end else begin
         nonce_valid <= 1'b0;
      end
   end
   assign exhausted = (st == W_DONE);

   // R4: reload lands on the slice start
   a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (nonce_valid && !exhausted && nonce == $past(first)));
   // R5: one step is one increment
   a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
      (nonce_valid && step && !start && nonce != last)
         |=> (nonce_valid && nonce == $past(nonce) + NONCE_W'(1)));
   // R5: no new value without a step
   a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !start) |=> !nonce_valid);
   // R7: exhaustion is sticky and silent
   a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (exhausted && !start) |=> (exhausted && !nonce_valid && $stable(nonce)));
   a_r7_enter: assert property (@(posedge clk) disable iff (!rst_n)
      (nonce_valid && step && !start && nonce == last) |=> (exhausted && !nonce_valid));
endmodule

// File: rtl/nonce_slice_walker.sv
module nonce_slice_walker #(
   parameter int unsigned NONCE_W     = 32,
   parameter int unsigned CNT_W       = 9,
   parameter bit          CLAMP_INDEX = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CNT_W-1:0]   chip_count,
   input  logic [CNT_W-1:0]   chip_index,
   input  logic               cfg_load,
   input  logic               cmd_ready,
   output logic               cmd_valid,
   output logic [7:0]         cmd_byte,
   input  logic               work_start,
   input  logic               step_en,
   output logic [NONCE_W-1:0] nonce,
   output logic               nonce_valid,
   output logic               exhausted
);
   logic [7:0]         calc_prefix, cfg_prefix;
   logic [NONCE_W-1:0] calc_first, calc_last, cfg_first, cfg_last;

   nsw_slice_calc #(
      .NONCE_W(NONCE_W), .CNT_W(CNT_W), .CLAMP_INDEX(CLAMP_INDEX)
   ) u_calc (
      .count(chip_count), .index(chip_index),
      .prefix(calc_prefix), .first(calc_first), .last(calc_last)
   );

   // R8: reset slice is the whole space of a one-chip chain
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_prefix <= 8'h00;
         cfg_first  <= '0;
         cfg_last   <= '1;
      end else if (cfg_load) begin
         cfg_prefix <= calc_prefix;
         cfg_first  <= calc_first;
         cfg_last   <= calc_last;
      end
   end

   nsw_cmd_seq u_cmd (
      .clk(clk), .rst_n(rst_n), .load(cfg_load), .prefix(cfg_prefix),
      .ready(cmd_ready), .valid(cmd_valid), .data(cmd_byte)
   );

   nsw_walker #(.NONCE_W(NONCE_W)) u_walk (
      .clk(clk), .rst_n(rst_n), .start(work_start), .step(step_en),
      .first(cfg_first), .last(cfg_last),
      .nonce(nonce), .nonce_valid(nonce_valid), .exhausted(exhausted)
   );

   // R6: a slice never ends before it starts
   a_r6_order: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_first <= cfg_last);
   // R2: a load opens the command with its first opcode
   a_r2_open: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |=> (cmd_valid && cmd_byte == 8'h41));
endmodule

// File: tb/nonce_slice_walker_tb.sv
module nonce_slice_walker_tb;
   localparam int NW = 16;
   localparam int CW = 9;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [CW-1:0] chip_count = '0, chip_index = '0;
   logic cfg_load = 0, cmd_ready = 0, work_start = 0, step_en = 0;
   logic cmd_valid, nonce_valid, exhausted;
   logic [7:0] cmd_byte;
   logic [NW-1:0] nonce;

   int checks = 0, errors = 0;
   bit done = 0;
   int cur_first, cur_last, cur_nonce;
   bit cur_exh;

   always #4 clk = ~clk;

   nonce_slice_walker #(.NONCE_W(NW), .CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .chip_count(chip_count), .chip_index(chip_index),
      .cfg_load(cfg_load), .cmd_ready(cmd_ready), .cmd_valid(cmd_valid),
      .cmd_byte(cmd_byte), .work_start(work_start), .step_en(step_en),
      .nonce(nonce), .nonce_valid(nonce_valid), .exhausted(exhausted)
   );

   function automatic int eff_cnt(int c); return (c == 0) ? 1 : c; endfunction
   function automatic int eff_idx(int c, int i);
      int k = eff_cnt(c);
      return (i >= k) ? k - 1 : i;
   endfunction
   function automatic int exp_prefix(int c, int i);
      return ((256 / eff_cnt(c)) * eff_idx(c, i)) & 255;
   endfunction
   function automatic int exp_last(int c, int i);
      int k = eff_cnt(c);
      int j = eff_idx(c, i);
      if (j == k - 1) return (1 << NW) - 1;
      return ((((256 / k) * (j + 1)) & 255) << (NW - 8)) - 1;
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // R2 R3 R1 R9: load and collect the four command bytes
   task automatic do_cfg(int c, int i);
      int got = 0;
      int guard = 0;
      logic [7:0] b[4];
      bit stalled = 0;
      logic [7:0] held = 0;
      chip_count = CW'(c); chip_index = CW'(i); cfg_load = 1;
      @(negedge clk); cfg_load = 0;
      check(cmd_valid == 1'b1, "R2 valid after load", int'(cmd_valid), 1);
      while (got < 4 && guard < 100) begin
         guard++;
         if (stalled)
            check(cmd_valid && cmd_byte == held, "R3 stall hold", int'(cmd_byte), int'(held));
         cmd_ready = ($urandom_range(0, 2) != 0);
         stalled = cmd_valid && !cmd_ready;
         held = cmd_byte;
         if (cmd_valid && cmd_ready) begin b[got] = cmd_byte; got++; end
         @(negedge clk);
      end
      cmd_ready = 0;
      check(got == 4, "R2 byte count", got, 4);
      check(cmd_valid == 1'b0, "R2 valid drops", int'(cmd_valid), 0);
      check(b[0] == 8'h41 && b[1] == 8'h05 && b[3] == 8'h00, "R2 opcode order",
            int'({b[0], b[1], b[3]}), 'h410500);
      check(int'(b[2]) == exp_prefix(c, i), "R1 R9 prefix byte", int'(b[2]), exp_prefix(c, i));
      cur_first = exp_prefix(c, i) << (NW - 8);
      cur_last  = exp_last(c, i);
   endtask

   // R4: reload
   task automatic do_start();
      work_start = 1;
      @(negedge clk); work_start = 0;
      cur_nonce = cur_first; cur_exh = 0;
      check(nonce_valid && !exhausted && int'(nonce) == cur_first, "R4 reload",
            int'(nonce), cur_first);
   endtask

   // R5 R6 R7: step n times and compare
   task automatic run_steps(int n, string tag);
      if (n == 0) return;
      step_en = 1;
      repeat (n) @(negedge clk);
      step_en = 0;
      if (!cur_exh && cur_nonce + n <= cur_last) begin
         cur_nonce = cur_nonce + n;
         check(nonce_valid && !exhausted && int'(nonce) == cur_nonce,
               {tag, " R5 step"}, int'(nonce), cur_nonce);
      end else begin
         cur_exh = 1; cur_nonce = cur_last;
         check(exhausted && !nonce_valid && int'(nonce) == cur_last,
               {tag, " R6 R7 end hold"}, int'(nonce), cur_last);
      end
      @(negedge clk);
      check(!nonce_valid, "R5 no value without step", int'(nonce_valid), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R8
      check(!cmd_valid && !nonce_valid && !exhausted, "R8 reset state",
            int'({cmd_valid, nonce_valid, exhausted}), 0);
      cur_first = 0; cur_last = (1 << NW) - 1;
      do_start();
      check(int'(nonce) == 0, "R8 reset slice start", int'(nonce), 0);

      // R10: two chips
      do_cfg(2, 0); do_start();
      check(int'(nonce) == 0, "R10 chip0 start", int'(nonce), 0);
      do_cfg(2, 1); do_start();
      check(int'(nonce) == 'h8000, "R10 chip1 start", int'(nonce), 'h8000);

      // R7: last chip of 256, run past the end, then idle stepping
      do_cfg(256, 255); do_start();
      run_steps(255, "last-chip");
      run_steps(1, "last-chip");
      run_steps(40, "after-end");
      do_start();   // R4 after exhaustion
      run_steps(10, "restart");
      do_start();   // R4 mid-slice
      run_steps(3, "mid");

      // R6: three chips, middle one ends below the third start
      do_cfg(3, 1); do_start();
      check(cur_last == 'hA9FF, "R6 bench end value", cur_last, 'hA9FF);
      run_steps(cur_last - cur_first + 1, "three-chip");

      // R1: count 0 as 1; R9: clamp
      do_cfg(0, 0); do_start();
      check(int'(nonce) == 0, "R1 zero count", int'(nonce), 0);
      do_cfg(4, 9); do_start();
      check(int'(nonce) == 'hC000, "R9 clamp start", int'(nonce), 'hC000);
      run_steps(16384, "clamp-end");

      // random mix
      for (int t = 0; t < 25; t++) begin
         int c = $urandom_range(0, 256);
         int i = $urandom_range(0, c + 2);
         do_cfg(c, i); do_start();
         run_steps($urandom_range(0, 300), "random");
         if ($urandom_range(0, 1) == 1) begin
            do_start();
            run_steps($urandom_range(1, 20), "random-restart");
         end
      end
      summary();
   end
endmodule